// File: doc/BRIEF.md
# Modular Effective Address Resolver

This block works out where the two operands of a two-field instruction live in a circular memory whose size is supplied at run time. Each operand has a three-bit addressing mode. The mode can be immediate, direct, or one of six indirect forms. An indirect form takes its pointer from either the first or the second field of an intermediate cell, and may decrement the pointer before use or increment it after use. All address arithmetic wraps modulo the run-time size `core_size`.

The caller presents an instruction on a one-cycle `start` strobe. The strobe carries the instruction's address, its two field values and its packed mode bits. The resolver then runs the memory reads and pointer write-backs it needs over a single-port memory interface. It resolves the first operand completely before it starts on the second. When both effective addresses and the four captured field values are valid, it raises `done` for one cycle. Those results are held until the next instruction is accepted. Executing the operation itself is left to the logic downstream.

Top module: `ear_resolver`

## Requirements
- R1: The first operand is resolved completely, including its pointer write-backs, before any memory access for the second operand. A second operand that reads a cell modified by the first therefore sees the modified value.
- R2: `instr_mode[2:0]` selects the first operand's mode and `instr_mode[5:3]` selects the second's. The codes are: 0 immediate, 1 direct, 2 indirect through field A, 3 predecrement through field A, 4 postincrement through field A, 5 indirect through field B, 6 predecrement through field B, 7 postincrement through field B.
- R3: An immediate operand's effective address is `instr_ip`. For an immediate first operand, its captured values are the instruction's own A and B fields. For an immediate second operand, its captured values are also the instruction's own A and B fields.
- R4: A direct operand's effective address is (operand field + `instr_ip`) mod `core_size`, and both fields of that cell are captured.
- R5: An indirect operand reads its pointer from the A or B field of the intermediate cell (operand field + `instr_ip`) mod `core_size`, as the mode selects. Its effective address is (pointer + intermediate address) mod `core_size`, and both fields of the final cell are captured.
- R6: A predecrement mode writes pointer-1 mod `core_size` back to the pointer field and uses that value. A pointer of 0 becomes `core_size`-1.
- R7: A postincrement mode writes pointer+1 mod `core_size` back after the final cell has been captured. A pointer of `core_size`-1 becomes 0, and the captured values are those seen before the increment, even when the final cell is the pointer's own cell.
- R8: A modular sum that reaches or passes `core_size` is brought back into range by one subtraction of `core_size`, for any run-time size.
- R9: `busy` is high from the cycle after a `start` is accepted until resolution ends. A `start` seen while `busy` is high is ignored and causes no memory access. While idle, the memory port is quiet.
- R10: `done` is a one-cycle pulse that marks valid results. Effective addresses and captured values hold until the next accepted `start`.
- R11: Every memory address issued, and every value written back, is below `core_size`, given inputs that are below `core_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_size | input | AW | Run-time memory size (modulus) |
| start | input | 1 | Accept a new instruction when idle |
| instr_ip | input | AW | Address of the instruction |
| instr_mode | input | 6 | Packed modes: [2:0] first operand, [5:3] second |
| instr_a | input | AW | Instruction's A field |
| instr_b | input | AW | Instruction's B field |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle pulse: results valid |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read both fields; data returns next cycle |
| mem_wr | output | 1 | Write one field |
| mem_wsel | output | 1 | Field written: 0 A field, 1 B field |
| mem_wdata | output | AW | Write data |
| mem_rdata_a | input | AW | Read data, A field |
| mem_rdata_b | input | AW | Read data, B field |
| ea_a | output | AW | Effective address of first operand |
| ea_b | output | AW | Effective address of second operand |
| opa_val_a | output | AW | First operand's captured A field |
| opa_val_b | output | AW | First operand's captured B field |
| opb_val_a | output | AW | Second operand's captured A field |
| opb_val_b | output | AW | Second operand's captured B field |

## Verification
Several rules hold on every cycle and are checked continuously: addresses and write data stay within the run-time modulus, reads and writes never overlap, the port is silent while idle, `done` is a single pulse that coincides with the end of `busy`, and results hold while idle. Whether the resolved addresses and captured values are right can only be shown by the bench scenarios, which compare them with an independent model of the memory. The same applies to the exact pointer values written back, the wraps at 0 and `core_size`-1, the ordering between the two operands, and the pre-increment capture on a self-referencing cell.

// File: rtl/ear_pkg.sv
package ear_pkg;

    localparam int MODE_W  = 3;
    localparam int NUM_OPS = 2;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM  = 3'd0,
        AM_DIR  = 3'd1,
        AM_AIND = 3'd2,
        AM_ADEC = 3'd3,
        AM_AINC = 3'd4,
        AM_BIND = 3'd5,
        AM_BDEC = 3'd6,
        AM_BINC = 3'd7
    } amode_e;

    typedef struct packed {
        logic imm;
        logic direct;
        logic from_a;
        logic pre_dec;
        logic post_inc;
    } mode_ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BEGIN,
        ST_PTR,
        ST_FETCH,
        ST_LATCH
    } rstate_e;

endpackage

// File: rtl/ear_mode_decode.sv
module ear_mode_decode
    import ear_pkg::*;
(
    input  amode_e    mode,
    output mode_ctl_t ctl
);
    always_comb begin
        ctl = '0;
        unique case (mode)
            AM_IMM:  ctl.imm = 1'b1;
            AM_DIR:  ctl.direct = 1'b1;
            AM_AIND: ctl.from_a = 1'b1;
            AM_ADEC: begin ctl.from_a = 1'b1; ctl.pre_dec = 1'b1; end
            AM_AINC: begin ctl.from_a = 1'b1; ctl.post_inc = 1'b1; end
            AM_BIND: ctl.from_a = 1'b0;
            AM_BDEC: ctl.pre_dec = 1'b1;
            AM_BINC: ctl.post_inc = 1'b1;
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/ear_mod_add.sv
module ear_mod_add #(
    parameter int W = 14
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] n,
    output logic [W-1:0] s
);
    logic [W:0] raw;
    logic [W:0] red;

    always_comb begin
        raw = {1'b0, x} + {1'b0, y};
        red = raw - {1'b0, n};
        s   = (raw >= {1'b0, n}) ? red[W-1:0] : raw[W-1:0];
    end
endmodule

// File: rtl/ear_mod_step.sv
module ear_mod_step #(
    parameter int W = 14
) (
    input  logic [W-1:0] v,
    input  logic [W-1:0] n,
    input  logic         down,
    output logic [W-1:0] r
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (down) r = (v == '0) ? (n - ONE) : (v - ONE);
        else      r = (v == (n - ONE)) ? '0 : (v + ONE);
    end
endmodule

// File: rtl/ear_resolver.sv
module ear_resolver
    import ear_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AW-1:0]         core_size,
    input  logic                  start,
    input  logic [AW-1:0]         instr_ip,
    input  logic [2*MODE_W-1:0]   instr_mode,
    input  logic [AW-1:0]         instr_a,
    input  logic [AW-1:0]         instr_b,
    output logic                  busy,
    output logic                  done,
    output logic [AW-1:0]         mem_addr,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic                  mem_wsel,
    output logic [AW-1:0]         mem_wdata,
    input  logic [AW-1:0]         mem_rdata_a,
    input  logic [AW-1:0]         mem_rdata_b,
    output logic [AW-1:0]         ea_a,
    output logic [AW-1:0]         ea_b,
    output logic [AW-1:0]         opa_val_a,
    output logic [AW-1:0]         opa_val_b,
    output logic [AW-1:0]         opb_val_a,
    output logic [AW-1:0]         opb_val_b
);
    rstate_e       state_q;
    logic          sel_q;
    logic [AW-1:0] ip_q;
    logic [AW-1:0] fld_q   [NUM_OPS];
    amode_e        mode_q  [NUM_OPS];
    mode_ctl_t     ctl_op  [NUM_OPS];
    logic [AW-1:0] ea_q    [NUM_OPS];
    logic [AW-1:0] va_q    [NUM_OPS];
    logic [AW-1:0] vb_q    [NUM_OPS];
    logic [AW-1:0] mid_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] fin_q;

    mode_ctl_t     ctl;
    logic [AW-1:0] cur_field;
    logic [AW-1:0] mid_sum;
    logic [AW-1:0] ptr_raw;
    logic [AW-1:0] ptr_dec;
    logic [AW-1:0] ptr_use;
    logic [AW-1:0] fin_sum;
    logic [AW-1:0] ptr_inc;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_dec
        ear_mode_decode u_dec (
            .mode (mode_q[g]),
            .ctl  (ctl_op[g])
        );
    end

    assign ctl       = ctl_op[sel_q];
    assign cur_field = fld_q[sel_q];
    assign ptr_raw   = ctl.from_a ? mem_rdata_a : mem_rdata_b;
    assign ptr_use   = ctl.pre_dec ? ptr_dec : ptr_raw;

    ear_mod_add #(.W(AW)) u_mid_add (
        .x (cur_field), .y (ip_q), .n (core_size), .s (mid_sum)
    );

    ear_mod_add #(.W(AW)) u_fin_add (
        .x (ptr_use), .y (mid_q), .n (core_size), .s (fin_sum)
    );

    ear_mod_step #(.W(AW)) u_dec_step (
        .v (ptr_raw), .n (core_size), .down (1'b1), .r (ptr_dec)
    );

    ear_mod_step #(.W(AW)) u_inc_step (
        .v (ptr_q), .n (core_size), .down (1'b0), .r (ptr_inc)
    );

    // memory port sequencing
    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wsel  = 1'b0;
        mem_wdata = '0;
        unique case (state_q)
            ST_BEGIN: begin
                if (!ctl.imm) begin
                    mem_rd   = 1'b1;
                    mem_addr = mid_sum;
                end
            end
            ST_PTR: begin
                if (ctl.pre_dec) begin
                    mem_wr    = 1'b1;
                    mem_addr  = mid_q;
                    mem_wsel  = ~ctl.from_a;
                    mem_wdata = ptr_dec;
                end
            end
            ST_FETCH: begin
                mem_rd   = 1'b1;
                mem_addr = fin_q;
            end
            ST_LATCH: begin
                if (ctl.post_inc) begin
                    mem_wr    = 1'b1;
                    mem_addr  = mid_q;
                    mem_wsel  = ~ctl.from_a;
                    mem_wdata = ptr_inc;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
            done    <= 1'b0;
            ip_q    <= '0;
            mid_q   <= '0;
            ptr_q   <= '0;
            fin_q   <= '0;
            for (int i = 0; i < NUM_OPS; i++) begin
                fld_q[i]  <= '0;
                mode_q[i] <= AM_IMM;
                ea_q[i]   <= '0;
                va_q[i]   <= '0;
                vb_q[i]   <= '0;
            end
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ip_q      <= instr_ip;
                        fld_q[0]  <= instr_a;
                        fld_q[1]  <= instr_b;
                        mode_q[0] <= amode_e'(instr_mode[MODE_W-1:0]);
                        mode_q[1] <= amode_e'(instr_mode[2*MODE_W-1:MODE_W]);
                        for (int i = 0; i < NUM_OPS; i++) begin
                            va_q[i] <= instr_a;
                            vb_q[i] <= instr_b;
                        end
                        sel_q   <= 1'b0;
                        state_q <= ST_BEGIN;
                    end
                end
                ST_BEGIN: begin
                    if (ctl.imm) begin
                        ea_q[sel_q] <= ip_q;
                        if (sel_q) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            sel_q   <= 1'b1;
                            state_q <= ST_BEGIN;
                        end
                    end else begin
                        mid_q <= mid_sum;
                        fin_q <= mid_sum;
                        ptr_q <= '0;
                        state_q <= ctl.direct ? ST_LATCH : ST_PTR;
                    end
                end
                ST_PTR: begin
                    ptr_q   <= ptr_use;
                    fin_q   <= fin_sum;
                    state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    state_q <= ST_LATCH;
                end
                ST_LATCH: begin
                    ea_q[sel_q] <= fin_q;
                    va_q[sel_q] <= mem_rdata_a;
                    vb_q[sel_q] <= mem_rdata_b;
                    if (sel_q) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end else begin
                        sel_q   <= 1'b1;
                        state_q <= ST_BEGIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign ea_a      = ea_q[0];
    assign ea_b      = ea_q[1];
    assign opa_val_a = va_q[0];
    assign opa_val_b = vb_q[0];
    assign opb_val_a = va_q[1];
    assign opb_val_b = vb_q[1];

endmodule

// File: rtl/ear_resolver_chk.sv
module ear_resolver_chk #(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] core_size,
    input logic          start,
    input logic [AW-1:0] instr_ip,
    input logic [AW-1:0] instr_a,
    input logic [AW-1:0] instr_b,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_wdata,
    input logic [AW-1:0] ea_a,
    input logic [AW-1:0] ea_b,
    input logic [AW-1:0] opa_val_a,
    input logic [AW-1:0] opa_val_b,
    input logic [AW-1:0] opb_val_a,
    input logic [AW-1:0] opb_val_b
);
    p_inputs_in_range_r11: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |-> (instr_ip < core_size && instr_a < core_size && instr_b < core_size));

    p_addr_in_range_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> (mem_addr < core_size));

    p_wdata_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_wdata < core_size));

    p_port_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_port_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr));

    p_busy_after_start_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_busy_ends_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(ea_a) && $stable(ea_b) && $stable(opa_val_a) &&
                               $stable(opa_val_b) && $stable(opb_val_a) && $stable(opb_val_b)));
endmodule

bind ear_resolver ear_resolver_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .core_size (core_size),
    .start     (start),
    .instr_ip  (instr_ip),
    .instr_a   (instr_a),
    .instr_b   (instr_b),
    .busy      (busy),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .ea_a      (ea_a),
    .ea_b      (ea_b),
    .opa_val_a (opa_val_a),
    .opa_val_b (opa_val_b),
    .opb_val_a (opb_val_a),
    .opb_val_b (opb_val_b)
);

// File: tb/ear_resolver_test.sv
module ear_resolver_test;
    localparam int AW    = 6;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] core_size = AW'(50);
    logic          start = 1'b0;
    logic [AW-1:0] instr_ip = '0;
    logic [5:0]    instr_mode = '0;
    logic [AW-1:0] instr_a = '0;
    logic [AW-1:0] instr_b = '0;
    logic          busy, done;
    logic [AW-1:0] mem_addr, mem_wdata;
    logic          mem_rd, mem_wr, mem_wsel;
    logic [AW-1:0] rd_a = '0;
    logic [AW-1:0] rd_b = '0;
    logic [AW-1:0] ea_a, ea_b, opa_val_a, opa_val_b, opb_val_a, opb_val_b;

    always #10 clk = ~clk;

    ear_resolver #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .core_size(core_size), .start(start),
        .instr_ip(instr_ip), .instr_mode(instr_mode), .instr_a(instr_a), .instr_b(instr_b),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wsel(mem_wsel), .mem_wdata(mem_wdata), .mem_rdata_a(rd_a), .mem_rdata_b(rd_b),
        .ea_a(ea_a), .ea_b(ea_b), .opa_val_a(opa_val_a), .opa_val_b(opa_val_b),
        .opb_val_a(opb_val_a), .opb_val_b(opb_val_b)
    );

    // memory model: one-cycle read latency, loader port used only while idle
    logic [AW-1:0] mem_a [DEPTH];
    logic [AW-1:0] mem_b [DEPTH];
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0, ld_a = '0, ld_b = '0;

    always @(posedge clk) begin
        if (ld_we) begin
            mem_a[ld_addr] <= ld_a;
            mem_b[ld_addr] <= ld_b;
        end else if (mem_wr) begin
            if (mem_wsel) mem_b[mem_addr] <= mem_wdata;
            else          mem_a[mem_addr] <= mem_wdata;
        end
        if (mem_rd) begin
            rd_a <= mem_a[mem_addr];
            rd_b <= mem_b[mem_addr];
        end
    end

    typedef struct {
        int    ea_a, ea_b, aa, ab, ba, bb;
        string tag;
    } exp_t;

    exp_t        sb[$];
    exp_t        last_exp;
    int          ref_a [DEPTH];
    int          ref_b [DEPTH];
    int          n_cur = 50;
    int          checks = 0;
    int          failures = 0;
    int          range_viol = 0;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int rnd(input int m);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) % m);
    endfunction

    task automatic poke(input int addr, input int va, input int vb);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = AW'(addr); ld_a = AW'(va); ld_b = AW'(vb);
        ref_a[addr] = va; ref_b[addr] = vb;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic load_all(input int n);
        n_cur = n;
        core_size = AW'(n);
        for (int i = 0; i < DEPTH; i++) poke(i, rnd(n), rnd(n));
    endtask

    // independent model of one operand's resolution on the reference memory
    task automatic model_op(input int mode, input int fld, input int ip,
                            output int ea, output int va, output int vb, output bit imm);
        int p, t;
        bit use_a;
        imm = (mode == 0);
        va = 0; vb = 0; ea = ip;
        if (!imm) begin
            p = (fld + ip) % n_cur;
            if (mode == 1) begin
                ea = p;
            end else begin
                use_a = (mode >= 2 && mode <= 4);
                t = use_a ? ref_a[p] : ref_b[p];
                if (mode == 3 || mode == 6) begin
                    t = (t == 0) ? n_cur - 1 : t - 1;
                    if (use_a) ref_a[p] = t; else ref_b[p] = t;
                end
                ea = (t + p) % n_cur;
            end
            va = ref_a[ea];
            vb = ref_b[ea];
            if (mode == 4 || mode == 7) begin
                t = (t == n_cur - 1) ? 0 : t + 1;
                if (use_a) ref_a[p] = t; else ref_b[p] = t;
            end
        end
    endtask

    task automatic issue(input int ip, input int ma, input int mb, input int fa, input int fb,
                         input string tag, input bit intrude);
        exp_t e;
        int ea, va, vb;
        bit imm;
        e.aa = fa; e.ab = fb; e.ba = fa; e.bb = fb; e.tag = tag;
        model_op(ma, fa, ip, ea, va, vb, imm);
        e.ea_a = ea;
        if (!imm) begin e.aa = va; e.ab = vb; end
        model_op(mb, fb, ip, ea, va, vb, imm);
        e.ea_b = ea;
        if (!imm) begin e.ba = va; e.bb = vb; end
        while (busy) @(negedge clk);
        sb.push_back(e);
        instr_ip = AW'(ip); instr_mode = {mb[2:0], ma[2:0]};
        instr_a = AW'(fa); instr_b = AW'(fb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            @(negedge clk);
            instr_ip = AW'(1); instr_mode = 6'b011_011; instr_a = AW'(2); instr_b = AW'(3);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
    endtask

    function automatic int mem_mismatch();
        int m = 0;
        for (int i = 0; i < DEPTH; i++)
            if (int'(mem_a[i]) != ref_a[i] || int'(mem_b[i]) != ref_b[i]) m++;
        return m;
    endfunction

    task automatic monitor();
        bit prev_done = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && (mem_rd || mem_wr) && int'(mem_addr) >= n_cur) range_viol++;
            if (prev_done) chk(!done, "R10", "done pulse width", int'(done), 0);
            prev_done = 1'b0;
            if (!rst && done) begin
                prev_done = 1'b1;
                if (sb.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    last_exp = e;
                    chk(int'(ea_a) == e.ea_a, e.tag, "ea_a", int'(ea_a), e.ea_a);
                    chk(int'(ea_b) == e.ea_b, e.tag, "ea_b", int'(ea_b), e.ea_b);
                    chk(int'(opa_val_a) == e.aa, e.tag, "opa_val_a", int'(opa_val_a), e.aa);
                    chk(int'(opa_val_b) == e.ab, e.tag, "opa_val_b", int'(opa_val_b), e.ab);
                    chk(int'(opb_val_a) == e.ba, e.tag, "opb_val_a", int'(opb_val_a), e.ba);
                    chk(int'(opb_val_b) == e.bb, e.tag, "opb_val_b", int'(opb_val_b), e.bb);
                    chk(mem_mismatch() == 0, e.tag, "memory cells differing", mem_mismatch(), 0);
                end
            end
        end
    endtask

    initial begin
        fork
            monitor();
            begin
                repeat (150000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired actual=timeout expected=completion");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state idle and quiet
        chk(!busy && !done, "R9", "busy/done after reset", int'({busy, done}), 0);
        chk(!mem_rd && !mem_wr, "R9", "port after reset", int'({mem_rd, mem_wr}), 0);

        load_all(50);
        // R3: both immediate
        issue(3, 0, 0, 7, 9, "R3", 1'b0);
        // R4: both direct
        issue(10, 1, 1, 4, 20, "R4", 1'b0);
        // R8: direct sums wrap past the modulus
        issue(45, 1, 1, 10, 49, "R8", 1'b0);
        // R5: indirect through A field, then through B field
        issue(10, 2, 5, 4, 6, "R5", 1'b0);
        // R6: predecrement of a zero pointer wraps to N-1
        poke(20, 0, 11);
        issue(15, 3, 0, 5, 2, "R6", 1'b0);
        // R7: postincrement of N-1 wraps to 0
        poke(30, 8, 49);
        issue(25, 0, 7, 1, 5, "R7", 1'b0);
        // R7: self-referencing postincrement captures pre-increment values
        poke(12, 0, 0);
        issue(12, 0, 7, 0, 0, "R7", 1'b0);
        // R1: first operand's predecrement is seen by the second operand
        poke(8, 10, 1);
        issue(5, 3, 1, 3, 3, "R1", 1'b0);
        // R9: start while busy is ignored
        issue(10, 6, 3, 4, 6, "R9", 1'b1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(!done && !busy, "R9", "activity after ignored start", int'({busy, done}), 0);
            chk(int'(ea_b) == last_exp.ea_b, "R10", "held ea_b", int'(ea_b), last_exp.ea_b);
        end
        chk(mem_mismatch() == 0, "R9", "memory after ignored start", mem_mismatch(), 0);

        // R2: all mode combinations under several sizes
        for (int k = 0; k < 64; k++)
            issue(rnd(50), k % 8, k / 8, rnd(50), rnd(50), "R2", 1'b0);
        load_all(7);
        for (int k = 0; k < 30; k++)
            issue(rnd(7), rnd(8), rnd(8), rnd(7), rnd(7), "R8", 1'b0);
        load_all(63);
        for (int k = 0; k < 30; k++)
            issue(rnd(63), rnd(8), rnd(8), rnd(63), rnd(63), "R8", 1'b0);

        chk(range_viol == 0, "R11", "out-of-range accesses", range_viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule